// File: doc/BRIEF.md
# I2C Master Random-Read Sequencer

This block is a two-wire bus master that fetches one byte from a serial memory at a chosen word address. A single start pulse launches one uninterrupted transaction. The block first addresses the device for writing and sends the word address, which sets the memory's internal pointer. It then turns the bus around with a repeated START, addresses the same device for reading, and clocks in one data byte. The bus stays owned by this master from the first START to the final STOP. No other master can step in and move the memory pointer between the two halves.

Both bus lines are open-drain. The block only pulls a line low or lets it go, through active-high output enables. The incoming SDA level passes through a two-flop synchroniser before use. Every SCL period is split into four quarters. Each quarter lasts `CLK_DIV` system clocks. SDA data changes in the first quarter while SCL is low. SCL is high during the second and third quarters, and SDA is sampled at the end of the third quarter.

The sequencer has these states:

| State | Action |
|-------|--------|
| `S_IDLE` | Waits for a start request. |
| `S_START` | Issues the START condition. |
| `S_DEVW` | Sends the device address with the write bit. |
| `S_ACKDW` | Checks the device's acknowledge. |
| `S_WORD` | Sends the word-address byte. |
| `S_ACKWD` | Checks the acknowledge for the word address. |
| `S_RSTART` | Issues the repeated START. |
| `S_DEVR` | Sends the device address with the read bit. |
| `S_ACKDR` | Checks the acknowledge for the read address. |
| `S_READ` | Shifts in the data byte. |
| `S_MNACK` | Sends a not-acknowledge. |
| `S_STOP` | Issues the STOP condition. |

Transitions:
- `S_IDLE` moves to `S_START` when a start request is accepted.
- `S_START` moves to `S_DEVW`.
- `S_DEVW` moves to `S_ACKDW` after 8 bits.
- `S_ACKDW` moves to `S_WORD` on an acknowledge, or to `S_STOP` on a missing acknowledge.
- `S_WORD` moves to `S_ACKWD` after 8 bits.
- `S_ACKWD` moves to `S_RSTART` on an acknowledge, or to `S_STOP` on a missing acknowledge.
- `S_RSTART` moves to `S_DEVR`.
- `S_DEVR` moves to `S_ACKDR` after 8 bits.
- `S_ACKDR` moves to `S_READ` on an acknowledge, or to `S_STOP` on a missing acknowledge.
- `S_READ` moves to `S_MNACK` after 8 bits.
- `S_MNACK` moves to `S_STOP`.
- `S_STOP` moves to `S_IDLE`.

Top module: `i2c_rand_read`

## Requirements
- R1: After reset both output enables are 0 (lines released), and `done_o` and `nack_err_o` are 0.
- R2: The bytes on the bus are sent MSB first, in this order:
  - the device address followed by a 0 bit (write),
  - the word address,
  - the device address followed by a 1 bit (read).
- R3: A successful transaction contains exactly two START conditions (the first START and the repeated START) and exactly one STOP. The STOP comes after the data byte, so the bus is never released between the write and read phases.
- R4: `rd_data_o` holds the byte returned by the memory, received MSB first, from `done_o` until the next completed read.
- R5: After the data byte the master leaves SDA high during the ninth clock (not-acknowledge) before the STOP.
- R6: A missing acknowledge (SDA high at the ninth clock) after any of the three address bytes ends the transaction:
  - no further byte is sent,
  - a STOP follows at once,
  - `nack_err_o` is 1 when `done_o` pulses and stays 1 until the next accepted start.
- R7: SDA changes while SCL is high only to form a START (falling) or a STOP (rising). In a full transaction there are exactly three such edges.
- R8: Within a byte, SCL rising edges are 4·`CLK_DIV` system clocks apart, and SCL stays high for 2·`CLK_DIV` clocks.
- R9: A start request that arrives while a transaction is running is ignored. The running transaction keeps its addresses, and no second transaction follows.
- R10: `done_o` is a one-cycle pulse, given once per transaction after the STOP has completed, with both lines released.
- R11: With no start request the block leaves both lines released and generates no SCL edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; accepted only when idle |
| dev_addr_i | input | DATA_W-1 | Device address, sampled at the accepted start |
| word_addr_i | input | DATA_W | Word address to read, sampled at the accepted start |
| sda_i | input | 1 | Level of the SDA line |
| rd_data_o | output | DATA_W | Byte read from the memory |
| done_o | output | 1 | One-cycle pulse when the STOP completes |
| nack_err_o | output | 1 | Set when an address byte was not acknowledged |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Three cases are hardest to reach from the ports:
- a missing acknowledge on the second device-address byte, after the repeated START,
- the acknowledge slots generally,
- the exact bus turnaround points.

A simple open-drain pull-up cannot reach any of them. The bench therefore includes a behavioural memory model that follows SCL and SDA edges itself. It decodes START and STOP, captures every byte, returns memory contents and records the master's ninth-bit level. The model can be told to withhold the acknowledge on a chosen byte. This lets each of the three abort points be reached in turn, and the counts of STARTs and STOPs prove that no bus release occurs mid-transaction.

// File: rtl/i2c_rand_read_pkg.sv
package i2c_rand_read_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_DEVW,
        S_ACKDW,
        S_WORD,
        S_ACKWD,
        S_RSTART,
        S_DEVR,
        S_ACKDR,
        S_READ,
        S_MNACK,
        S_STOP
    } seq_state_t;

    // per-quarter drive request; 1 means pull the line low
    typedef struct packed {
        logic scl_low;
        logic sda_low;
        logic cond;      // slot that forms a START or STOP condition
    } bus_drive_t;

    localparam logic RW_WRITE = 1'b0;
    localparam logic RW_READ  = 1'b1;

    function automatic logic is_ack_state(input seq_state_t s);
        return (s == S_ACKDW) || (s == S_ACKWD) || (s == S_ACKDR);
    endfunction

    function automatic logic is_tx_state(input seq_state_t s);
        return (s == S_DEVW) || (s == S_WORD) || (s == S_DEVR);
    endfunction

endpackage

// File: rtl/i2c_rand_read_qtick.sv
module i2c_rand_read_qtick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == CW'(DIV - 1));

            // R8: quarter ticks are never back to back when DIV > 1
            p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_nodiv
            assign tick = run;
        end
    endgenerate

endmodule

// File: rtl/i2c_rand_read_shreg.sv
module i2c_rand_read_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q,
    output logic         msb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

    assign msb = q[W-1];

    // R2: a load and a shift never collide
    p_load_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/i2c_rand_read.sv
module i2c_rand_read
    import i2c_rand_read_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-2:0] dev_addr_i,
    input  logic [DATA_W-1:0] word_addr_i,
    input  logic              sda_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              nack_err_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o
);
    localparam int DEV_W = DATA_W - 1;
    localparam int BC_W  = $clog2(DATA_W);

    seq_state_t        state, nstate;
    logic [1:0]        qtr;
    logic [BC_W-1:0]   bitc;
    logic [DEV_W-1:0]  dev_q;
    logic [DATA_W-1:0] word_q;
    logic              sda_s1, sda_s2;
    logic              ack_ok, err_pend;
    logic              tick, run, accept, sample, slot_end, last_bit;
    logic              sh_load, sh_shift, sh_msb;
    logic [DATA_W-1:0] sh_val, sh_q;
    bus_drive_t        drv;
    logic              cond_q;

    assign run      = (state != S_IDLE);
    assign accept   = (state == S_IDLE) && start_i;
    assign sample   = tick && (qtr == 2'd2);
    assign slot_end = tick && (qtr == 2'd3);
    assign last_bit = (bitc == BC_W'(DATA_W - 1));

    i2c_rand_read_qtick #(.DIV(CLK_DIV)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    i2c_rand_read_shreg #(.W(DATA_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .load_val(sh_val),
        .shift   (sh_shift),
        .sin     (sda_s2),
        .q       (sh_q),
        .msb     (sh_msb)
    );

    // shifter control
    always_comb begin
        sh_load = 1'b0;
        sh_val  = '0;
        if (accept) begin
            sh_load = 1'b1;
            sh_val  = {dev_addr_i, RW_WRITE};
        end else if (slot_end && state == S_ACKDW && ack_ok) begin
            sh_load = 1'b1;
            sh_val  = word_q;
        end else if (slot_end && state == S_RSTART) begin
            sh_load = 1'b1;
            sh_val  = {dev_q, RW_READ};
        end
        sh_shift = (slot_end && is_tx_state(state)) || (sample && state == S_READ);
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (accept)               nstate = S_START;
            S_START:  if (slot_end)             nstate = S_DEVW;
            S_DEVW:   if (slot_end && last_bit) nstate = S_ACKDW;
            S_ACKDW:  if (slot_end)             nstate = ack_ok ? S_WORD : S_STOP;
            S_WORD:   if (slot_end && last_bit) nstate = S_ACKWD;
            S_ACKWD:  if (slot_end)             nstate = ack_ok ? S_RSTART : S_STOP;
            S_RSTART: if (slot_end)             nstate = S_DEVR;
            S_DEVR:   if (slot_end && last_bit) nstate = S_ACKDR;
            S_ACKDR:  if (slot_end)             nstate = ack_ok ? S_READ : S_STOP;
            S_READ:   if (slot_end && last_bit) nstate = S_MNACK;
            S_MNACK:  if (slot_end)             nstate = S_STOP;
            S_STOP:   if (slot_end)             nstate = S_IDLE;
            default:                            nstate = S_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            qtr      <= 2'd0;
            bitc     <= '0;
            dev_q    <= '0;
            word_q   <= '0;
            ack_ok   <= 1'b0;
            err_pend <= 1'b0;
            sda_s1   <= 1'b1;
            sda_s2   <= 1'b1;
        end else begin
            sda_s1 <= sda_i;
            sda_s2 <= sda_s1;
            state  <= nstate;
            if (!run) begin
                qtr <= 2'd0;
            end else if (tick) begin
                qtr <= qtr + 2'd1;
            end
            if (accept) begin
                dev_q    <= dev_addr_i;
                word_q   <= word_addr_i;
                ack_ok   <= 1'b0;
                err_pend <= 1'b0;
            end
            if (slot_end) begin
                if ((is_tx_state(state) || state == S_READ) && !last_bit) begin
                    bitc <= bitc + 1'b1;
                end else begin
                    bitc <= '0;
                end
            end
            if (sample && is_ack_state(state)) begin
                ack_ok <= !sda_s2;
            end
            if (slot_end && is_ack_state(state) && !ack_ok) begin
                err_pend <= 1'b1;
            end
        end
    end

    // per-quarter bus drive pattern
    always_comb begin
        drv = '{scl_low: 1'b0, sda_low: 1'b0, cond: 1'b0};
        unique case (state)
            S_IDLE: ;
            S_START: begin
                drv.scl_low = (qtr == 2'd3);
                drv.sda_low = (qtr >= 2'd2);
                drv.cond    = 1'b1;
            end
            S_RSTART: begin
                drv.scl_low = (qtr == 2'd0) || (qtr == 2'd3);
                drv.sda_low = (qtr >= 2'd2);
                drv.cond    = 1'b1;
            end
            S_DEVW, S_WORD, S_DEVR: begin
                drv.scl_low = (qtr == 2'd0) || (qtr == 2'd3);
                drv.sda_low = !sh_msb;
            end
            S_ACKDW, S_ACKWD, S_ACKDR, S_READ, S_MNACK: begin
                drv.scl_low = (qtr == 2'd0) || (qtr == 2'd3);
                drv.sda_low = 1'b0;
            end
            S_STOP: begin
                drv.scl_low = (qtr == 2'd0);
                drv.sda_low = (qtr <= 2'd1);
                drv.cond    = 1'b1;
            end
            default: ;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe_o   <= 1'b0;
            sda_oe_o   <= 1'b0;
            cond_q     <= 1'b0;
            done_o     <= 1'b0;
            nack_err_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            scl_oe_o <= drv.scl_low;
            sda_oe_o <= drv.sda_low;
            cond_q   <= drv.cond;
            done_o   <= slot_end && (state == S_STOP);
            if (accept) begin
                nack_err_o <= 1'b0;
            end else if (slot_end && state == S_STOP) begin
                nack_err_o <= err_pend;
            end
            if (slot_end && state == S_READ && last_bit) begin
                rd_data_o <= sh_q;
            end
        end
    end

    // R7: outside START/STOP slots SDA is quiet while SCL is released
    p_sda_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe_o && !$past(scl_oe_o) && !cond_q && !$past(cond_q))
        |-> (sda_oe_o == $past(sda_oe_o)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: bus is released when done is reported
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!scl_oe_o && !sda_oe_o));

    // R6: a missing acknowledge leads straight to STOP
    p_ack_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && is_ack_state(state) && !ack_ok) |=> (state == S_STOP));

    // R6: error is raised together with done
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_err_o) |-> done_o);

    // R9: latched addresses hold while a transaction runs
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(word_q) && $stable(dev_q)));

    // R11: idle leaves both lines released
    p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state) == S_IDLE) |=> (!scl_oe_o && !sda_oe_o));

endmodule

// File: tb/test_i2c_rand_read.sv
module test_i2c_rand_read;
    localparam int DIV = 4;
    localparam logic [6:0] SLV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [6:0] dev_addr_i = '0;
    logic [7:0] word_addr_i = '0;
    logic [7:0] rd_data_o;
    logic done_o, nack_err_o, scl_oe_o, sda_oe_o;
    logic slv_low = 1'b0;
    logic scl, sda;

    always #2 clk = ~clk;

    assign scl = ~scl_oe_o;
    assign sda = ~(sda_oe_o | slv_low);

    i2c_rand_read #(.CLK_DIV(DIV), .DATA_W(8)) i_i2c_rand_read (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dev_addr_i(dev_addr_i), .word_addr_i(word_addr_i), .sda_i(sda),
        .rd_data_o(rd_data_o), .done_o(done_o), .nack_err_o(nack_err_o),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    function automatic logic [7:0] memf(input logic [7:0] a);
        return (a * 8'd7) ^ 8'h3C;
    endfunction

    // behavioural memory on the bus
    int starts = 0, stops = 0, pc = 0, bidx = 0, ncap = 0, nrise = 0, nfall = 0;
    int inject = 0, scl_edges = 0;
    logic tx = 0, rdm = 0, acked = 0, mack_bit = 0;
    logic [7:0] sh = 0, ptr = 0, txb = 0;
    logic [7:0] cap [0:2];
    realtime rise_t [0:3];
    realtime fall_t [0:3];

    always @(negedge sda) if (scl === 1'b1) begin
        starts++; pc = 0; bidx = 0; tx = 0; rdm = 0; slv_low = 0;
    end
    always @(posedge sda) if (scl === 1'b1) stops++;

    always @(posedge scl) begin
        scl_edges++;
        if (nrise < 4) rise_t[nrise] = $realtime;
        nrise++;
        if (pc < 8 && !tx) sh = {sh[6:0], sda};
        if (pc == 8 && tx) mack_bit = sda;
        pc = pc + 1;
    end

    always @(negedge scl) begin
        scl_edges++;
        if (nfall < 4) fall_t[nfall] = $realtime;
        nfall++;
        if (pc == 8 && !tx) begin
            if (ncap < 3) cap[ncap] = sh;
            ncap++;
            acked = 0;
            if (bidx == 0) begin
                if (sh[7:1] == SLV && inject != (sh[0] ? 3 : 1)) begin
                    acked = 1; rdm = sh[0];
                end
            end else if (bidx == 1 && !rdm) begin
                if (inject != 2) begin acked = 1; ptr = sh; end
            end
            slv_low = acked;
        end else if (pc == 8 && tx) begin
            slv_low = 0;
        end else if (pc == 9) begin
            slv_low = 0; pc = 0;
            if (tx) tx = 0;
            else if (bidx == 0 && acked && rdm) begin
                tx = 1; txb = memf(ptr); slv_low = !txb[7];
            end
            bidx++;
        end else if (tx && pc >= 1 && pc <= 7) begin
            slv_low = !txb[7 - pc];
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int dones = 0;

    task automatic clear_mon();
        starts = 0; stops = 0; ncap = 0; nrise = 0; nfall = 0;
        mack_bit = 0; dones = 0;
        for (int i = 0; i < 3; i++) cap[i] = 8'hxx;
    endtask

    task automatic pulse_start(input logic [6:0] d, input logic [7:0] w);
        @(negedge clk);
        dev_addr_i = d; word_addr_i = w; start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    // waits for done, checks pulse width and bus release (R10)
    task automatic wait_done();
        int n;
        n = 0;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        chk("R10 done seen", done_o, 1);
        if (done_o) dones++;
        chk("R10 lines released at done", {scl_oe_o, sda_oe_o}, 0);
        chk("R10 stop already complete", stops, 1);
        @(negedge clk);
        chk("R10 done one cycle", done_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 scl released", scl_oe_o, 0);
        chk("R1 sda released", sda_oe_o, 0);
        chk("R1 done low", done_o, 0);
        chk("R1 err low", nack_err_o, 0);
    endtask

    task automatic t_read(input logic [7:0] w);
        clear_mon(); inject = 0;
        pulse_start(SLV, w);
        wait_done();
        chk("R2 dev write byte", cap[0], {SLV, 1'b0});
        chk("R2 word byte", cap[1], w);
        chk("R2 dev read byte", cap[2], {SLV, 1'b1});
        chk("R3 start count", starts, 2);
        chk("R3 stop count", stops, 1);
        chk("R4 read data", rd_data_o, memf(w));
        chk("R5 master nack", mack_bit, 1);
        chk("R7 sda edges under scl high", starts + stops, 3);
        chk("R6 no error", nack_err_o, 0);
    endtask

    task automatic t_timing();
        clear_mon(); inject = 0;
        pulse_start(SLV, 8'h11);
        wait_done();
        chk("R8 scl period", longint'((rise_t[2] - rise_t[1]) / 4.0), 4 * DIV);
        chk("R8 scl high time", longint'((fall_t[2] - rise_t[1]) / 4.0), 2 * DIV);
    endtask

    task automatic t_nack(input logic [6:0] d, input int inj, input int exp_starts, input int exp_cap);
        clear_mon(); inject = inj;
        pulse_start(d, 8'h42);
        wait_done();
        chk("R6 error flag", nack_err_o, 1);
        chk("R6 starts before abort", starts, exp_starts);
        chk("R6 bytes sent", ncap, exp_cap);
        repeat (20) @(negedge clk);
        chk("R6 error held", nack_err_o, 1);
        inject = 0;
    endtask

    task automatic t_err_clear();
        clear_mon();
        pulse_start(SLV, 8'h05);
        @(negedge clk);
        chk("R6 error cleared at start", nack_err_o, 0);
        wait_done();
        chk("R4 data after error", rd_data_o, memf(8'h05));
    endtask

    task automatic t_ignore();
        clear_mon(); inject = 0;
        pulse_start(SLV, 8'h9C);
        repeat (300) @(negedge clk);
        pulse_start(7'h23, 8'h01);
        wait_done();
        chk("R9 word kept", cap[1], 8'h9C);
        chk("R9 data kept", rd_data_o, memf(8'h9C));
        repeat (200) @(negedge clk);
        chk("R9 no second transfer", starts, 2);
        chk("R9 single done", dones, 1);
    endtask

    task automatic t_idle();
        int e0;
        e0 = scl_edges;
        repeat (200) @(negedge clk);
        chk("R11 no scl edges", scl_edges - e0, 0);
        chk("R11 lines released", {scl_oe_o, sda_oe_o}, 0);
        chk("R4 data held", rd_data_o, memf(8'h9C));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (3) @(negedge clk);
        t_reset();
        t_read(8'h00);
        t_read(8'hA7);
        t_read(8'hFF);
        t_timing();
        t_nack(7'h2B, 0, 1, 1);
        t_nack(SLV, 2, 1, 2);
        t_nack(SLV, 3, 2, 3);
        t_err_clear();
        t_ignore();
        t_idle();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule